// File: doc/BRIEF.md
# Collision Retry and Late-Collision Controller

This block follows one half-duplex transmit attempt at a time. It decides what the transmitter does when the attempt ends. It counts the frame bytes that go onto the wire, leaving out preamble and start delimiter. A collision seen while that count is still inside a programmable window is an early collision, and the frame is sent again. A collision seen after the window is a late collision, and the frame is dropped without retry. The block also counts consecutive retries of the same frame. Once a programmable number of retries has been used, the next early collision drops the frame with an excess-collision status.

The transmit engine raises `att_start` to open an attempt. It strobes `byte_tick` once per payload byte and raises `att_end` when the last byte has gone out. The medium interface drives `coll_det`. All control and status pins are plain single-cycle levels, and the block has no data stream and no back-pressure. Each attempt produces exactly one registered outcome pulse, and the engine reacts to that pulse. Typical settings are a window of 0x37 bytes and a retry limit of 0xF. Backoff delay and the frame datapath are handled elsewhere.

Top module: `coll_retry_ctrl`

## Requirements
- R1: `att_start` while no attempt is open opens an attempt and clears the byte count. Each `byte_tick` during an open attempt adds one to the count. A collision is early when the count is less than or equal to `win_bytes`, so a count equal to the window still counts as early.
- R2: An early collision when the retries used so far are fewer than `retry_max` gives a one-cycle `retry_o` pulse and adds one to the retries used.
- R3: An early collision when the retries used equal or exceed `retry_max` gives a one-cycle `xs_abort_o` pulse. `retry_max` = 0 therefore allows no retry, and `retry_max` = 15 allows 15 retries, so the 16th early collision aborts.
- R4: A collision when the count is greater than `win_bytes` gives a one-cycle `late_abort_o` pulse and no retry. This holds even when the retry limit is already reached.
- R5: `att_end` during an open attempt with no collision in that cycle gives a one-cycle `done_o` pulse.
- R6: The retries used return to zero after any `done_o`, `late_abort_o` or `xs_abort_o` outcome.
- R7: The byte count stops at 2^(WIN_W+1)-1 and does not wrap. With WIN_W = 6, a window of 63 and 130 bytes sent, a collision is late.
- R8: Every outcome pulse comes one clock after the cycle of the event that causes it. At most one of the four outputs is high in any cycle, an outcome closes the attempt, and no outcome pulse lasts longer than one cycle.
- R9: When `coll_det` and `att_end` are high in the same cycle, the collision outcome is given and `done_o` stays low. A `byte_tick` in the same cycle as a collision is not counted for that decision.
- R10: `coll_det`, `att_end` and `byte_tick` have no effect while no attempt is open: no outcome pulse and no change to the retries used. `att_start` while an attempt is open is ignored and does not clear the byte count.
- R11: During and after reset, all four outputs are low, no attempt is open and the retries used are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| att_start | input | 1 | Opens a transmit attempt |
| att_end | input | 1 | Last byte of the attempt has been sent |
| byte_tick | input | 1 | One payload byte sent (no preamble or delimiter) |
| coll_det | input | 1 | Collision seen on the medium |
| win_bytes | input | WIN_W | Early-collision window in bytes |
| retry_max | input | RETRY_W | Retries allowed before excess abort |
| retry_o | output | 1 | Pulse: send the frame again |
| late_abort_o | output | 1 | Pulse: frame dropped, late collision |
| xs_abort_o | output | 1 | Pulse: frame dropped, too many collisions |
| done_o | output | 1 | Pulse: frame sent without collision |

## Verification
Two pairs of events can fall in the same cycle. A collision can arrive in the same cycle as the end-of-frame strobe, and a byte strobe can arrive in the same cycle as a collision. The bench creates both by driving the two inputs in one cycle. It expects the collision outcome with `done_o` low. In the byte-strobe case the window equals the bytes sent before that cycle, so counting the extra byte would wrongly turn the retry into a late abort. Window edges are checked at count equal to the window and at one byte above it, and the retry limit is checked at 0 and at 15.

// File: rtl/coll_retry_pkg.sv
package coll_retry_pkg;
  typedef enum logic [2:0] {
    OC_NONE,
    OC_DONE,
    OC_RETRY,
    OC_LATE,
    OC_EXCESS
  } outcome_e;
endpackage

// File: rtl/coll_byte_window.sv
module coll_byte_window #(
  parameter int WIN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [WIN_W-1:0] win,
  output logic             past_win
);
  localparam int CNT_W = WIN_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (tick && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  assign past_win = cnt > {1'b0, win};

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R1
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_TOP && !clr) |=> cnt == CNT_TOP); // R7
endmodule

// File: rtl/coll_retry_count.sv
module coll_retry_count #(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               clr,
  input  logic [RETRY_W-1:0] limit,
  output logic               exhausted
);
  logic [RETRY_W-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   used <= '0;
    else if (clr) used <= '0;
    else if (inc) used <= used + 1'b1;
  end

  assign exhausted = used >= limit;

  AST_RETRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> used == '0); // R6
  AST_NO_RETRY_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !exhausted); // R3
endmodule

// File: rtl/coll_outcome_sel.sv
module coll_outcome_sel
  import coll_retry_pkg::*;
(
  input  logic     active,
  input  logic     coll,
  input  logic     frame_end,
  input  logic     past_win,
  input  logic     exhausted,
  output outcome_e outcome
);
  always_comb begin
    outcome = OC_NONE;
    if (active) begin
      if (coll) begin
        if (past_win)       outcome = OC_LATE;
        else if (exhausted) outcome = OC_EXCESS;
        else                outcome = OC_RETRY;
      end else if (frame_end) begin
        outcome = OC_DONE;
      end
    end
  end
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
  import coll_retry_pkg::*;
#(
  parameter int WIN_W   = 6,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               att_start,
  input  logic               att_end,
  input  logic               byte_tick,
  input  logic               coll_det,
  input  logic [WIN_W-1:0]   win_bytes,
  input  logic [RETRY_W-1:0] retry_max,
  output logic               retry_o,
  output logic               late_abort_o,
  output logic               xs_abort_o,
  output logic               done_o
);
  logic     active;
  logic     open_now;
  logic     past_win;
  logic     exhausted;
  outcome_e outcome;

  assign open_now = att_start && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 active <= 1'b0;
    else if (outcome != OC_NONE) active <= 1'b0;
    else if (open_now)          active <= 1'b1;
  end

  coll_byte_window #(.WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (open_now),
    .tick     (byte_tick && active),
    .win      (win_bytes),
    .past_win (past_win)
  );

  coll_retry_count #(.RETRY_W(RETRY_W)) u_rty (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (outcome == OC_RETRY),
    .clr       (outcome == OC_DONE || outcome == OC_LATE || outcome == OC_EXCESS),
    .limit     (retry_max),
    .exhausted (exhausted)
  );

  coll_outcome_sel u_sel (
    .active    (active),
    .coll      (coll_det),
    .frame_end (att_end),
    .past_win  (past_win),
    .exhausted (exhausted),
    .outcome   (outcome)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_o      <= 1'b0;
      late_abort_o <= 1'b0;
      xs_abort_o   <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      retry_o      <= outcome == OC_RETRY;
      late_abort_o <= outcome == OC_LATE;
      xs_abort_o   <= outcome == OC_EXCESS;
      done_o       <= outcome == OC_DONE;
    end
  end

  logic any_out;
  assign any_out = retry_o | late_abort_o | xs_abort_o | done_o;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_o, late_abort_o, xs_abort_o, done_o})); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |=> !any_out); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !any_out); // R10
  AST_COLL_BEATS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (active && coll_det) |=> !done_o); // R9
  AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && coll_det && past_win) |=> late_abort_o); // R4
endmodule

// File: tb/sim_coll_retry_ctrl.sv
module sim_coll_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic att_start = 1'b0, att_end = 1'b0, byte_tick = 1'b0, coll_det = 1'b0;
  logic [5:0] win_bytes = 6'd55;
  logic [3:0] retry_max = 4'd15;
  logic retry_o, late_abort_o, xs_abort_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  coll_retry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .att_start(att_start), .att_end(att_end),
    .byte_tick(byte_tick), .coll_det(coll_det), .win_bytes(win_bytes),
    .retry_max(retry_max), .retry_o(retry_o), .late_abort_o(late_abort_o),
    .xs_abort_o(xs_abort_o), .done_o(done_o)
  );

  // outcome codes: 0 done, 1 retry, 2 late, 3 excess, 4 none
  function automatic logic [3:0] code_vec(input int code);
    case (code)
      0: return 4'b0001;
      1: return 4'b0010;
      2: return 4'b0100;
      3: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check_out(input int code, input string req);
    logic [3:0] got;
    got = {xs_abort_o, late_abort_o, retry_o, done_o};
    checks++;
    if (got !== code_vec(code)) begin
      errors++;
      $display("FAIL %s: outputs {xs,late,retry,done}=%b expected %b", req, got, code_vec(code));
    end
  endtask

  task automatic open_attempt(input int nbytes);
    att_start = 1'b1;
    @(negedge clk);
    att_start = 1'b0;
    if (nbytes > 0) begin
      byte_tick = 1'b1;
      repeat (nbytes) @(negedge clk);
      byte_tick = 1'b0;
    end
  endtask

  // act: 1 collision, 0 end of frame; check one clock later
  task automatic finish_attempt(input bit act, input int code, input string req);
    if (act) coll_det = 1'b1; else att_end = 1'b1;
    @(negedge clk);
    coll_det = 1'b0;
    att_end = 1'b0;
    check_out(code, req);
    @(negedge clk);
    check_out(4, "R8 pulse width");
  endtask

  // {win[20:15], max[14:11], bytes[10:3], act[2], expected[1:0]}
  localparam logic [20:0] VEC [0:11] = '{
    {6'd55, 4'd2,  8'd10,  1'b1, 2'd1},  // R2 early retry
    {6'd55, 4'd2,  8'd55,  1'b1, 2'd1},  // R1 count equals window: early
    {6'd55, 4'd2,  8'd0,   1'b1, 2'd3},  // R3 limit used: excess
    {6'd55, 4'd2,  8'd56,  1'b1, 2'd2},  // R4 one byte past window
    {6'd55, 4'd2,  8'd30,  1'b0, 2'd0},  // R5 clean end
    {6'd0,  4'd15, 8'd0,   1'b1, 2'd1},  // R1 zero window, no bytes
    {6'd0,  4'd15, 8'd1,   1'b1, 2'd2},  // R4 zero window, one byte
    {6'd63, 4'd15, 8'd63,  1'b1, 2'd1},  // R1 widest window edge
    {6'd63, 4'd15, 8'd64,  1'b1, 2'd2},  // R4 past widest window
    {6'd63, 4'd15, 8'd130, 1'b1, 2'd2},  // R7 saturation, no wrap
    {6'd55, 4'd0,  8'd60,  1'b1, 2'd2},  // R4 late beats exhausted
    {6'd55, 4'd0,  8'd20,  1'b0, 2'd0}   // R5 done with zero limit
  };

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out(4, "R11 outputs during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_out(4, "R11 outputs after reset");

    foreach (VEC[i]) begin
      win_bytes = VEC[i][20:15];
      retry_max = VEC[i][14:11];
      open_attempt(int'(VEC[i][10:3]));
      finish_attempt(VEC[i][2], int'(VEC[i][1:0]), $sformatf("R1-table vector %0d", i));
    end

    // R10: idle events ignored, retries used untouched
    win_bytes = 6'd55;
    retry_max = 4'd1;
    for (int k = 0; k < 3; k++) begin
      coll_det = 1'b1; att_end = 1'b1; byte_tick = 1'b1;
      @(negedge clk);
      coll_det = 1'b0; att_end = 1'b0; byte_tick = 1'b0;
      check_out(4, "R10 idle collision/end");
    end
    open_attempt(2);
    finish_attempt(1'b1, 1, "R10 retries untouched by idle collisions");
    open_attempt(2);
    finish_attempt(1'b0, 0, "R5 clear after R10");

    // R9: collision and end together
    retry_max = 4'd15;
    open_attempt(5);
    coll_det = 1'b1; att_end = 1'b1;
    @(negedge clk);
    coll_det = 1'b0; att_end = 1'b0;
    check_out(1, "R9 collision with end");
    @(negedge clk);

    // R9: byte strobe with collision not counted
    win_bytes = 6'd3;
    open_attempt(3);
    coll_det = 1'b1; byte_tick = 1'b1;
    @(negedge clk);
    coll_det = 1'b0; byte_tick = 1'b0;
    check_out(1, "R9 byte with collision");
    @(negedge clk);
    open_attempt(0);
    finish_attempt(1'b0, 0, "R6 clear after R9");

    // R3: zero limit
    win_bytes = 6'd55;
    retry_max = 4'd0;
    open_attempt(4);
    finish_attempt(1'b1, 3, "R3 zero limit");

    // R3: limit 15 gives 15 retries then excess
    retry_max = 4'd15;
    for (int k = 0; k < 15; k++) begin
      open_attempt(1);
      finish_attempt(1'b1, 1, "R3 retry below 15");
    end
    open_attempt(1);
    finish_attempt(1'b1, 3, "R3 16th collision");

    // R6: done clears retries used
    retry_max = 4'd2;
    open_attempt(1); finish_attempt(1'b1, 1, "R6 first retry");
    open_attempt(1); finish_attempt(1'b1, 1, "R6 second retry");
    open_attempt(1); finish_attempt(1'b0, 0, "R6 done");
    open_attempt(1); finish_attempt(1'b1, 1, "R6 retry after done");
    open_attempt(1); finish_attempt(1'b1, 1, "R6 second retry after done");
    open_attempt(1); finish_attempt(1'b1, 3, "R6 excess after refill");

    // R10: second start while open is ignored
    win_bytes = 6'd5;
    retry_max = 4'd15;
    open_attempt(5);
    open_attempt(1);
    finish_attempt(1'b1, 2, "R10 start while open ignored");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end
endmodule